// File: doc/BRIEF.md
# Transfer FIFO and Interrupt Unit

This unit sits between a host register bus and the bit-level engine of an I2C master. The host queues command words into a transmit FIFO. The engine takes them from the other side, one at a time. Bytes that the engine receives go into a receive FIFO, and the host reads them out of it. Each FIFO holds 64 entries. Each has its own clear control and its own watermark. Each also keeps two sticky error flags: one for a pop from an empty FIFO, one for a push into a full FIFO.

Five interrupt causes are latched in one register:

- transfer complete and transfer error, both pulsed by the engine;
- FIFO error, raised while any sticky error flag is set;
- receive almost full and transmit almost empty, driven by the watermarks.

A mask register selects which latched causes drive the single interrupt line. The host clears a latched cause by writing 1 to its bit in the clear register.

The host bus is a single-cycle strobe interface with word addresses. A write takes effect at the clock edge on which it is strobed. Read data is combinational from the address. A read of the receive-data address pops one byte at that edge. The reset input is asynchronous and active low, and its release is synchronised inside the unit.

Host address map (3-bit word address):

| Address | Access | Content |
|---|---|---|
| 0 | write | push a command word |
| 1 | read | pop a received byte |
| 2 | read/write | FIFO control |
| 3 | read | FIFO status |
| 4 | read/write | interrupt mask |
| 5 | write | interrupt clear |
| 6 | read | masked interrupt status |
| 7 | read | raw latched causes |

Top module: `xfer_fifo_irq`

## Requirements
- R1: A command word written to address 0 is pushed into the transmit FIFO. The engine sees the oldest entry on eng_cmd_data, with eng_cmd_valid high whenever the FIFO is not empty, and eng_cmd_pop removes it. Order is first in, first out. After 64 pushes, status bit 11 (transmit full) reads 1. Status bit 9 (transmit empty) reads 1 when the transmit FIFO holds nothing.
- R2: A byte pushed with eng_rx_push is read back, oldest first, on host_rdata[7:0] by a read of address 1, and that read pops the byte. Status bit 3 (receive empty) reads 1 when the receive FIFO holds nothing. Status bit 4 (receive full) reads 1 when it holds 64 bytes.
- R3: A push into a full FIFO drops the data, leaves the fill level unchanged and sets that FIFO's write-error flag. The transmit write-error flag is status bit 7; the receive write-error flag is status bit 1.
- R4: A pop from an empty FIFO returns the value most recently popped from that FIFO and sets its read-error flag. The transmit read-error flag is status bit 6; the receive read-error flag is status bit 0.
- R5: The error flags stay set until a write to the control register (address 2) sets the matching clear bit: bit 0 for receive, bit 1 for transmit. A clear empties that FIFO and resets only that FIFO's flags.
- R6: Cause bit 2 (FIFO error) is latched on every cycle in which any of the four error flags is set.
- R7: Cause bit 3 (receive almost full) is latched on every cycle in which the receive fill level is greater than or equal to the threshold in control bits 7:2.
- R8: Cause bit 4 (transmit almost empty) is latched on every cycle in which the transmit fill level is less than or equal to the threshold in control bits 13:8.
- R9: A one-cycle pulse on eng_done latches cause bit 0 (transfer complete). A one-cycle pulse on eng_err latches cause bit 1 (transfer error).
- R10: Writing 1 to a bit of address 5 clears that latched cause. Writing 0 leaves the cause unchanged. A set condition present in the same cycle wins over the clear.
- R11: Address 6 reads the latched causes ANDed with the mask at address 4, where a 1 enables a cause. irq is 1 exactly when that AND is non-zero.
- R12: Reset state:
  - both FIFOs are empty and all error flags are 0, so status reads 0x0208;
  - the mask and both thresholds are 0, so irq is 0;
  - with zero thresholds both level conditions hold, so the raw causes read 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Word address |
| host_wdata | input | DATA_W (16) | Write data |
| host_rdata | output | DATA_W (16) | Read data for host_addr |
| eng_cmd_valid | output | 1 | Transmit FIFO holds a command |
| eng_cmd_data | output | CMD_W (11) | Oldest command, or the last popped command when empty |
| eng_cmd_pop | input | 1 | Engine takes one command |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_data | input | BYTE_W (8) | Received byte |
| eng_done | input | 1 | Transfer complete pulse |
| eng_err | input | 1 | Bus error pulse |
| irq | output | 1 | Interrupt line |

## Verification
The bench fills the transmit FIFO to exactly 64 entries and then pushes once more. A design with an off-by-one full flag would either accept that word, so it would reach the engine, or refuse the 64th word. It then pops past empty and expects the last command again. A design that returns stale memory, or that fails to set the read-error flag, shows up at that point.

Both watermarks are tested at the exact boundary level and one step away from it. A wrong comparison operator would move the event one entry early or late.

Clearing one FIFO while the other FIFO's flag is set checks that a clear does not leak across FIFOs. Writing zeros to the clear register checks that a design which treats any write as a clear would lose causes.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

  localparam int HOST_AW = 3;

  typedef enum logic [HOST_AW-1:0] {
    ADR_CMD   = 3'd0,
    ADR_RXD   = 3'd1,
    ADR_CTRL  = 3'd2,
    ADR_STAT  = 3'd3,
    ADR_MASK  = 3'd4,
    ADR_CLR   = 3'd5,
    ADR_MSTAT = 3'd6,
    ADR_RAW   = 3'd7
  } host_addr_e;

  localparam int N_CAUSE = 5;
  localparam int CS_DONE = 0;
  localparam int CS_TERR = 1;
  localparam int CS_FERR = 2;
  localparam int CS_RXAF = 3;
  localparam int CS_TXAE = 4;

  localparam int ST_RX_RERR  = 0;
  localparam int ST_RX_WERR  = 1;
  localparam int ST_RX_EMPTY = 3;
  localparam int ST_RX_FULL  = 4;
  localparam int ST_TX_RERR  = 6;
  localparam int ST_TX_WERR  = 7;
  localparam int ST_TX_EMPTY = 9;
  localparam int ST_TX_FULL  = 11;

  localparam int CT_RX_CLR   = 0;
  localparam int CT_TX_CLR   = 1;
  localparam int CT_RX_THR   = 2;

endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CNT_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             rd_err,
  output logic             wr_err
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [WIDTH-1:0] last_q;
  logic             rd_err_q, rd_err_n, wr_err_q, wr_err_n;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    rd_err_n = rd_err_q;
    wr_err_n = wr_err_q;
    if (clr) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
      rd_err_n = 1'b0;
      wr_err_n = 1'b0;
    end else begin
      if (do_push) wr_ptr_n = ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_n = ptr_inc(rd_ptr_q);
      if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
      if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
      if (pop && empty) rd_err_n = 1'b1;
      if (push && full) wr_err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rd_err_q <= 1'b0;
      wr_err_q <= 1'b0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
      rd_err_q <= rd_err_n;
      wr_err_q <= wr_err_n;
      if (do_pop) last_q <= mem[rd_ptr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  assign pop_data = empty ? last_q : mem[rd_ptr_q];
  assign level    = cnt_q;
  assign rd_err   = rd_err_q;
  assign wr_err   = wr_err_q;

  // R1: fill level never exceeds the depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  // R3: a push into a full FIFO leaves the level alone and flags it
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (level == $past(level)) && wr_err);

  // R4: a pop from an empty FIFO flags an underflow
  a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !clr) |=> rd_err);

  // R5: error flags hold until a clear
  a_r5_rd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !clr) |=> rd_err);
  a_r5_wr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !clr) |=> wr_err);
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty && !rd_err && !wr_err);

endmodule

// File: rtl/xfer_irq_unit.sv
module xfer_irq_unit #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic         irq
);

  logic [N-1:0] raw_q, raw_n, mask_q, mask_n;

  always_comb begin
    raw_n  = raw_q;
    mask_n = mask_q;
    if (clr_we)  raw_n  = raw_n & ~clr_bits;
    raw_n = raw_n | set_i;
    if (mask_we) mask_n = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_n;
      mask_q <= mask_n;
    end
  end

  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = |(raw_q & mask_q);

  // R9: a set condition is latched at the next edge
  a_r9_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((raw & $past(set_i)) == $past(set_i)));

  // R10: write-1 bits without a concurrent set are gone after the edge
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw & $past(clr_bits & ~set_i)) == '0));

  // R10: no clear write and no set keeps the causes unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && set_i == '0) |=> $stable(raw));

  // R11: all causes masked keeps the line quiet
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CMD_W  = 11,
  parameter int BYTE_W = 8,
  parameter int THR_W  = 6,
  parameter int DATA_W = 16,
  localparam int CNT_W      = $clog2(DEPTH) + 1,
  localparam int TX_THR_LSB = CT_RX_THR + THR_W,
  localparam int CTRL_TOP   = TX_THR_LSB + THR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              eng_cmd_valid,
  output logic [CMD_W-1:0]  eng_cmd_data,
  input  logic              eng_cmd_pop,
  input  logic              eng_rx_push,
  input  logic [BYTE_W-1:0] eng_rx_data,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              irq
);

  logic rst_s_n;
  xfer_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  logic wr_cmd, rd_rxd, wr_ctrl, wr_mask, wr_clr;
  assign wr_cmd  = host_sel &&  host_wr && (host_addr == ADR_CMD);
  assign rd_rxd  = host_sel && !host_wr && (host_addr == ADR_RXD);
  assign wr_ctrl = host_sel &&  host_wr && (host_addr == ADR_CTRL);
  assign wr_mask = host_sel &&  host_wr && (host_addr == ADR_MASK);
  assign wr_clr  = host_sel &&  host_wr && (host_addr == ADR_CLR);

  logic             tx_clr, rx_clr;
  assign rx_clr = wr_ctrl && host_wdata[CT_RX_CLR];
  assign tx_clr = wr_ctrl && host_wdata[CT_TX_CLR];

  logic [THR_W-1:0] rx_thr_q, rx_thr_n, tx_thr_q, tx_thr_n;

  always_comb begin
    rx_thr_n = rx_thr_q;
    tx_thr_n = tx_thr_q;
    if (wr_ctrl) begin
      rx_thr_n = host_wdata[CT_RX_THR +: THR_W];
      tx_thr_n = host_wdata[TX_THR_LSB +: THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rx_thr_q <= '0;
      tx_thr_q <= '0;
    end else begin
      rx_thr_q <= rx_thr_n;
      tx_thr_q <= tx_thr_n;
    end
  end

  logic [CNT_W-1:0]  tx_level, rx_level;
  logic              tx_empty, tx_full, tx_rerr, tx_werr;
  logic              rx_empty, rx_full, rx_rerr, rx_werr;
  logic [BYTE_W-1:0] rx_byte;

  xfer_fifo #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_txq (
    .clk(clk), .rst_n(rst_s_n), .clr(tx_clr),
    .push(wr_cmd), .push_data(host_wdata[CMD_W-1:0]),
    .pop(eng_cmd_pop), .pop_data(eng_cmd_data),
    .level(tx_level), .empty(tx_empty), .full(tx_full),
    .rd_err(tx_rerr), .wr_err(tx_werr)
  );

  xfer_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk(clk), .rst_n(rst_s_n), .clr(rx_clr),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(rd_rxd), .pop_data(rx_byte),
    .level(rx_level), .empty(rx_empty), .full(rx_full),
    .rd_err(rx_rerr), .wr_err(rx_werr)
  );

  assign eng_cmd_valid = !tx_empty;

  logic [N_CAUSE-1:0] cause_set, raw, mask;
  always_comb begin
    cause_set          = '0;
    cause_set[CS_DONE] = eng_done;
    cause_set[CS_TERR] = eng_err;
    cause_set[CS_FERR] = tx_rerr | tx_werr | rx_rerr | rx_werr;
    cause_set[CS_RXAF] = (rx_level >= CNT_W'(rx_thr_q));
    cause_set[CS_TXAE] = (tx_level <= CNT_W'(tx_thr_q));
  end

  xfer_irq_unit #(.N(N_CAUSE)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .set_i(cause_set),
    .clr_we(wr_clr), .clr_bits(host_wdata[N_CAUSE-1:0]),
    .mask_we(wr_mask), .mask_wdata(host_wdata[N_CAUSE-1:0]),
    .raw(raw), .mask(mask), .irq(irq)
  );

  logic [DATA_W-1:0] stat;
  always_comb begin
    stat              = '0;
    stat[ST_RX_RERR]  = rx_rerr;
    stat[ST_RX_WERR]  = rx_werr;
    stat[ST_RX_EMPTY] = rx_empty;
    stat[ST_RX_FULL]  = rx_full;
    stat[ST_TX_RERR]  = tx_rerr;
    stat[ST_TX_WERR]  = tx_werr;
    stat[ST_TX_EMPTY] = tx_empty;
    stat[ST_TX_FULL]  = tx_full;
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADR_RXD:   host_rdata = DATA_W'(rx_byte);
      ADR_CTRL:  host_rdata = DATA_W'({tx_thr_q, rx_thr_q, 2'b00});
      ADR_STAT:  host_rdata = stat;
      ADR_MASK:  host_rdata = DATA_W'(mask);
      ADR_MSTAT: host_rdata = DATA_W'(raw & mask);
      ADR_RAW:   host_rdata = DATA_W'(raw);
      default:   host_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^host_wdata[DATA_W-1:CTRL_TOP];

  // R2: the host never sees an empty flag while the FIFO reports a level
  a_r2_empty_level: assert property (@(posedge clk) disable iff (!rst_s_n)
    stat[ST_RX_EMPTY] |-> (rx_level == '0));

  // R6: a set error flag shows up as the FIFO-error cause one edge later
  a_r6_ferr: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tx_rerr || tx_werr || rx_rerr || rx_werr) |=> raw[CS_FERR]);

endmodule

// File: tb/sim_xfer_fifo_irq.sv
`timescale 1ns/1ps
module sim_xfer_fifo_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        eng_cmd_valid;
  logic [10:0] eng_cmd_data;
  logic        eng_cmd_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_done = 1'b0, eng_err = 1'b0;
  logic        irq;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xfer_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_data(eng_cmd_data),
    .eng_cmd_pop(eng_cmd_pop), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_done(eng_done), .eng_err(eng_err),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  task automatic epop(output logic [10:0] d);
    @(negedge clk);
    eng_cmd_pop = 1'b1;
    #1 d = eng_cmd_data;
    @(negedge clk);
    eng_cmd_pop = 1'b0;
  endtask

  task automatic epush(input logic [7:0] b);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    idle(4);
    hrd(3'd3, d); chk("R12 status after reset", d, 16'h0208);
    hrd(3'd4, d); chk("R12 mask after reset", d, 16'h0000);
    hrd(3'd2, d); chk("R12 thresholds after reset", d, 16'h0000);
    hrd(3'd7, d); chk("R12 raw causes after reset", d, 16'h0018);
    chk("R12 irq after reset", irq, 1'b0);
  endtask

  task automatic t_tx_order();
    logic [10:0] c;
    hwr(3'd0, 16'h0123); hwr(3'd0, 16'h0456); hwr(3'd0, 16'h07AB);
    chk("R1 valid after push", eng_cmd_valid, 1'b1);
    epop(c); chk("R1 first command", c, 11'h123);
    epop(c); chk("R1 second command", c, 11'h456);
    epop(c); chk("R1 third command", c, 11'h7AB);
    idle(1);
    chk("R1 valid after drain", eng_cmd_valid, 1'b0);
  endtask

  task automatic t_tx_full();
    logic [15:0] d;
    logic [10:0] c;
    int bad;
    for (int i = 0; i < 64; i++) hwr(3'd0, 16'(i + 16'h100));
    hrd(3'd3, d); chk("R1 transmit full at 64", d & 16'h0A80, 16'h0800);
    hwr(3'd0, 16'h07FF);
    hrd(3'd3, d); chk("R3 transmit write error", d & 16'h0880, 16'h0880);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      epop(c);
      if (c !== 11'(i + 16'h100)) bad++;
    end
    chk("R3 overflow word dropped, order kept", bad, 0);
    epop(c); chk("R4 empty pop returns last command", c, 11'h13F);
    hrd(3'd3, d); chk("R4 transmit read error", d & 16'h00C0, 16'h00C0);
    idle(2);
    hrd(3'd7, d); chk("R6 FIFO-error cause", d & 16'h0004, 16'h0004);
    hwr(3'd2, 16'h0002);
    hrd(3'd3, d); chk("R5 transmit clear resets flags", d, 16'h0208);
    hwr(3'd5, 16'h0004);
    idle(2);
    hrd(3'd7, d); chk("R6 cause stays clear once flags gone", d & 16'h0004, 16'h0000);
  endtask

  task automatic t_rx();
    logic [15:0] d;
    logic [10:0] c;
    epush(8'hA1); epush(8'hB2); epush(8'hC3);
    hrd(3'd3, d); chk("R2 receive not empty", d & 16'h0008, 16'h0000);
    hrd(3'd1, d); chk("R2 first byte", d, 16'h00A1);
    hrd(3'd1, d); chk("R2 second byte", d, 16'h00B2);
    hrd(3'd1, d); chk("R2 third byte", d, 16'h00C3);
    hrd(3'd3, d); chk("R2 receive empty", d & 16'h0009, 16'h0008);
    hrd(3'd1, d); chk("R4 empty read returns last byte", d, 16'h00C3);
    hrd(3'd3, d); chk("R4 receive read error", d & 16'h0001, 16'h0001);
    epop(c);
    for (int i = 0; i < 65; i++) epush(8'(i));
    hrd(3'd3, d); chk("R3 receive full and write error", d & 16'h0012, 16'h0012);
    hwr(3'd2, 16'h0001);
    hrd(3'd3, d); chk("R5 receive clear leaves transmit flag", d, 16'h0248);
    hwr(3'd2, 16'h0002);
    hrd(3'd3, d); chk("R5 transmit clear", d, 16'h0208);
    hwr(3'd5, 16'h001F);
  endtask

  task automatic t_thr();
    logic [15:0] d;
    logic [10:0] c;
    hwr(3'd2, 16'h0210);
    hrd(3'd2, d); chk("R7 R8 thresholds read back", d, 16'h0210);
    hwr(3'd0, 16'h0001); hwr(3'd0, 16'h0002); hwr(3'd0, 16'h0003);
    idle(1);
    hwr(3'd5, 16'h001F);
    idle(2);
    hrd(3'd7, d); chk("R8 level 3 above threshold 2", d & 16'h0018, 16'h0000);
    epop(c);
    idle(2);
    hrd(3'd7, d); chk("R8 level 2 equals threshold", d & 16'h0010, 16'h0010);
    epush(8'h11); epush(8'h22); epush(8'h33);
    idle(2);
    hrd(3'd7, d); chk("R7 level 3 below threshold 4", d & 16'h0008, 16'h0000);
    epush(8'h44);
    idle(2);
    hrd(3'd7, d); chk("R7 level 4 reaches threshold", d & 16'h0008, 16'h0008);
    hwr(3'd2, 16'h0213);
    hwr(3'd2, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    hwr(3'd5, 16'h001F);
    @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    hrd(3'd7, d); chk("R9 transfer complete latched", d & 16'h0003, 16'h0001);
    chk("R11 irq low with zero mask", irq, 1'b0);
    hwr(3'd4, 16'h0001);
    idle(1);
    chk("R11 irq with complete enabled", irq, 1'b1);
    hrd(3'd6, d); chk("R11 masked status", d, 16'h0001);
    @(negedge clk); eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
    hrd(3'd7, d); chk("R9 transfer error latched", d & 16'h0003, 16'h0003);
    hwr(3'd5, 16'h0000);
    hrd(3'd7, d); chk("R10 zero write leaves causes", d & 16'h0003, 16'h0003);
    hwr(3'd5, 16'h0001);
    hrd(3'd7, d); chk("R10 one clears only its bit", d & 16'h0003, 16'h0002);
    chk("R11 irq drops after clear", irq, 1'b0);
    hwr(3'd4, 16'h0002);
    idle(1);
    chk("R11 irq with error enabled", irq, 1'b1);
    hrd(3'd6, d); chk("R11 masked status error only", d, 16'h0002);
    hwr(3'd4, 16'h0010);
    hrd(3'd6, d); chk("R11 masked almost-empty", d, 16'h0010);
    hwr(3'd4, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_thr();
    t_irq();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule